// File: doc/BRIEF.md
# Dual-Threshold Ingress Token-Bucket Policer

This block polices the frames of one ingress port against a single bucket. Each frame that is charged adds a cost to a fill level: the selected counted quantity multiplied by a programmable increment. A periodic drain tick subtracts a programmable rate from the fill. The fill is compared against a committed threshold and an excess threshold. From that comparison the block decides whether the frame passes, is dropped, or passes while a pause request is raised.

The configuration is presented as static inputs. A one-cycle initialise pulse clears the bucket's running state and leaves the configuration untouched. An all-zero configuration disables the resource. The pause request is a registered level that is released at one of two selectable points.

Top module: `ingress_policer`

## Requirements
- R1: The counted quantity is chosen by `count_sel_i`. Code 0 counts 1 per frame. Code 1 counts `frm_len_i`+20 (wire bytes). Code 2 counts `frm_len_i` (layer-2 bytes). Code 3 counts `frm_len_i`-18, floored at 0 (layer-3 bytes). The frame cost is that quantity times `incr_i`.
- R2: `dec_valid_o` is high in the cycle after each `frm_valid_i` pulse and low otherwise. `dec_pass_o` then carries the decision: 1 means pass, 0 means drop. After reset, `dec_valid_o` and `pause_o` are 0.
- R3: A frame that arrives while the fill is below `cbs_i` passes and is charged, whatever the excess threshold.
- R4: A frame that arrives with the fill at or above `cbs_i`, and with fill+cost not above `ebs_i`, passes and is charged.
- R5: If `limit_en_i`=1 and `exceed_fc_i`=0, a frame with fill at or above `cbs_i` and fill+cost above `ebs_i` is dropped and is not charged.
- R6: If `limit_en_i`=1 and `exceed_fc_i`=1, such an exceeding frame passes, is charged, and sets `pause_o` from the next cycle. `pause_o` rises only for this reason.
- R7: With `limit_en_i`=0, every frame passes and is charged, and no pause is raised.
- R8: A drain tick lowers the fill by `rate_factor_i`, with a floor at 0. If a frame and a tick fall in the same cycle, the charge is applied before the drain. The fill is held at 2^FILL_W-1 at most.
- R9: With `release_at_cbs_i`=0, the pause request is released in the cycle in which the updated fill reaches 0.
- R10: With `release_at_cbs_i`=1, the pause request is released in the cycle in which the updated fill drops below `cbs_i`.
- R11: An `init_i` pulse clears the fill and the pause request and leaves the configuration in force.
- R12: When every configuration input is zero, the resource is disabled. Frames pass and are not charged, and `pause_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_factor_i | input | RATE_W | Amount drained per tick |
| incr_i | input | INC_W | Cost multiplier per counted unit |
| cbs_i | input | LIM_W | Committed threshold |
| ebs_i | input | LIM_W | Excess threshold |
| exceed_fc_i | input | 1 | Action on exceed: 0 drop, 1 pause |
| release_at_cbs_i | input | 1 | Pause release point: 0 empty, 1 below committed |
| limit_en_i | input | 1 | 0 accept all frames, 1 apply the exceed action |
| count_sel_i | input | 2 | Counted quantity select |
| init_i | input | 1 | Clear the running state |
| drain_tick_i | input | 1 | Drain strobe |
| frm_valid_i | input | 1 | Frame end event |
| frm_len_i | input | LEN_W | Frame length in layer-2 bytes |
| dec_valid_o | output | 1 | Decision valid |
| dec_pass_o | output | 1 | Decision: 1 pass, 0 drop |
| pause_o | output | 1 | Pause request level |

## Verification
The hardest state to reach from the ports is a held pause request that is then released by draining alone. Reaching it needs a fill first driven above the committed threshold. Then one charged frame must push fill+cost past the excess threshold. Then a sequence of ticks must step the fill through the two release points. The directed cases choose a drain rate that stops between the committed threshold and zero, so the two release modes give different results. A seeded random phase then mixes frames, ticks and initialise pulses under changing configurations. Every decision is compared with a bench model of the fill.

// File: rtl/policer_pkg.sv
package policer_pkg;
  typedef enum logic [1:0] {
    CNT_FRAME = 2'd0,
    CNT_WIRE  = 2'd1,
    CNT_LINK  = 2'd2,
    CNT_NET   = 2'd3
  } cnt_sel_e;

  localparam int unsigned WIRE_EXTRA = 20;
  localparam int unsigned NET_STRIP  = 18;
endpackage

// File: rtl/policer_cost.sv
module policer_cost
  import policer_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned INC_W = 12
) (
  input  logic [LEN_W-1:0]       len_i,
  input  logic [1:0]             sel_i,
  input  logic [INC_W-1:0]       incr_i,
  output logic [LEN_W+INC_W:0]   cost_o
);
  localparam int unsigned QTY_W  = LEN_W + 1;
  localparam int unsigned COST_W = LEN_W + INC_W + 1;

  logic [QTY_W-1:0] len_x, qty;
  assign len_x = {1'b0, len_i};

  always_comb begin
    unique case (cnt_sel_e'(sel_i))
      CNT_FRAME: qty = QTY_W'(1);
      CNT_WIRE:  qty = len_x + QTY_W'(WIRE_EXTRA);
      CNT_LINK:  qty = len_x;
      default:   qty = (len_x >= QTY_W'(NET_STRIP)) ? len_x - QTY_W'(NET_STRIP) : '0;
    endcase
  end

  assign cost_o = COST_W'(qty) * COST_W'(incr_i);
endmodule

// File: rtl/policer_decide.sv
module policer_decide #(
  parameter int unsigned FILL_W = 26,
  parameter int unsigned COST_W = 29,
  parameter int unsigned LIM_W  = 24
) (
  input  logic              frm_valid_i,
  input  logic              disabled_i,
  input  logic              limit_en_i,
  input  logic              exceed_fc_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [COST_W-1:0] cost_i,
  input  logic [LIM_W-1:0]  cbs_i,
  input  logic [LIM_W-1:0]  ebs_i,
  output logic              pass_o,
  output logic              charge_o,
  output logic              set_pause_o
);
  localparam int unsigned W0    = (FILL_W > COST_W) ? FILL_W : COST_W;
  localparam int unsigned W1    = (W0 > LIM_W) ? W0 : LIM_W;
  localparam int unsigned CMP_W = W1 + 1;

  logic below_cbs, over_ebs;
  assign below_cbs = CMP_W'(fill_i) < CMP_W'(cbs_i);
  assign over_ebs  = (CMP_W'(fill_i) + CMP_W'(cost_i)) > CMP_W'(ebs_i);

  always_comb begin
    pass_o      = 1'b1;
    charge_o    = 1'b0;
    set_pause_o = 1'b0;
    if (frm_valid_i && !disabled_i) begin
      if (below_cbs || !limit_en_i || !over_ebs) begin
        charge_o = 1'b1;
      end else if (exceed_fc_i) begin
        charge_o    = 1'b1;
        set_pause_o = 1'b1;
      end else begin
        pass_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/policer_bucket.sv
module policer_bucket #(
  parameter int unsigned FILL_W = 26,
  parameter int unsigned COST_W = 29,
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              charge_i,
  input  logic [COST_W-1:0] cost_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [FILL_W-1:0] fill_o,
  output logic [FILL_W-1:0] fill_next_o
);
  localparam int unsigned SUM_W = ((FILL_W > COST_W) ? FILL_W : COST_W) + 1;
  localparam logic [FILL_W-1:0] FILL_MAX = '1;

  logic [FILL_W-1:0] fill_q, charged;
  logic [SUM_W-1:0]  sum;

  assign sum     = SUM_W'(fill_q) + (charge_i ? SUM_W'(cost_i) : '0);
  assign charged = (sum > SUM_W'(FILL_MAX)) ? FILL_MAX : sum[FILL_W-1:0];

  always_comb begin
    fill_next_o = charged;
    if (tick_i)
      fill_next_o = (charged >= FILL_W'(rate_i)) ? charged - FILL_W'(rate_i) : '0;
    if (clear_i)
      fill_next_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= fill_next_o;
  end

  assign fill_o = fill_q;
endmodule

// File: rtl/ingress_policer.sv
module ingress_policer #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned INC_W  = 12,
  parameter int unsigned RATE_W = 16,
  parameter int unsigned LIM_W  = 24,
  parameter int unsigned FILL_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_factor_i,
  input  logic [INC_W-1:0]  incr_i,
  input  logic [LIM_W-1:0]  cbs_i,
  input  logic [LIM_W-1:0]  ebs_i,
  input  logic              exceed_fc_i,
  input  logic              release_at_cbs_i,
  input  logic              limit_en_i,
  input  logic [1:0]        count_sel_i,
  input  logic              init_i,
  input  logic              drain_tick_i,
  input  logic              frm_valid_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  output logic              dec_valid_o,
  output logic              dec_pass_o,
  output logic              pause_o
);
  localparam int unsigned COST_W = LEN_W + INC_W + 1;
  localparam int unsigned CMP_W  = ((FILL_W > LIM_W) ? FILL_W : LIM_W) + 1;

  logic [COST_W-1:0] cost;
  logic [FILL_W-1:0] fill_q, fill_next;
  logic pass, charge, set_pause, disabled, release_hit;
  logic dec_valid_q, dec_pass_q, pause_q;

  assign disabled = ~|{rate_factor_i, incr_i, cbs_i, ebs_i, exceed_fc_i,
                       release_at_cbs_i, limit_en_i, count_sel_i};

  policer_cost #(.LEN_W(LEN_W), .INC_W(INC_W)) i_cost (
    .len_i  (frm_len_i),
    .sel_i  (count_sel_i),
    .incr_i (incr_i),
    .cost_o (cost)
  );

  policer_decide #(.FILL_W(FILL_W), .COST_W(COST_W), .LIM_W(LIM_W)) i_decide (
    .frm_valid_i (frm_valid_i),
    .disabled_i  (disabled),
    .limit_en_i  (limit_en_i),
    .exceed_fc_i (exceed_fc_i),
    .fill_i      (fill_q),
    .cost_i      (cost),
    .cbs_i       (cbs_i),
    .ebs_i       (ebs_i),
    .pass_o      (pass),
    .charge_o    (charge),
    .set_pause_o (set_pause)
  );

  policer_bucket #(.FILL_W(FILL_W), .COST_W(COST_W), .RATE_W(RATE_W)) i_bucket (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (init_i | disabled),
    .charge_i    (charge),
    .cost_i      (cost),
    .tick_i      (drain_tick_i),
    .rate_i      (rate_factor_i),
    .fill_o      (fill_q),
    .fill_next_o (fill_next)
  );

  // release is judged on the fill after this cycle's charge and drain
  assign release_hit = release_at_cbs_i ? (CMP_W'(fill_next) < CMP_W'(cbs_i))
                                        : (fill_next == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_q <= 1'b0;
      dec_pass_q  <= 1'b0;
      pause_q     <= 1'b0;
    end else begin
      dec_valid_q <= frm_valid_i;
      if (frm_valid_i) dec_pass_q <= pass;
      if (init_i || disabled)          pause_q <= 1'b0;
      else if (set_pause)              pause_q <= 1'b1;
      else if (pause_q && release_hit) pause_q <= 1'b0;
    end
  end

  assign dec_valid_o = dec_valid_q;
  assign dec_pass_o  = dec_pass_q;
  assign pause_o     = pause_q;
endmodule

// File: rtl/policer_checker.sv
module policer_checker #(
  parameter int unsigned RATE_W = 16,
  parameter int unsigned INC_W  = 12,
  parameter int unsigned LIM_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [RATE_W-1:0] rate_factor_i,
  input logic [INC_W-1:0]  incr_i,
  input logic [LIM_W-1:0]  cbs_i,
  input logic [LIM_W-1:0]  ebs_i,
  input logic              exceed_fc_i,
  input logic              release_at_cbs_i,
  input logic              limit_en_i,
  input logic [1:0]        count_sel_i,
  input logic              init_i,
  input logic              frm_valid_i,
  input logic              dec_valid_o,
  input logic              dec_pass_o,
  input logic              pause_o
);
  logic cfg_zero;
  assign cfg_zero = ~|{rate_factor_i, incr_i, cbs_i, ebs_i, exceed_fc_i,
                       release_at_cbs_i, limit_en_i, count_sel_i};

  AST_DEC_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> dec_valid_o); // R2
  AST_DEC_ONLY_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> !dec_valid_o); // R2
  AST_ACCEPT_MODE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && !limit_en_i) |=> dec_pass_o); // R7
  AST_PAUSE_MODE_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && exceed_fc_i) |=> dec_pass_o); // R6
  AST_PAUSE_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_o) |-> $past(frm_valid_i && limit_en_i && exceed_fc_i)); // R6
  AST_INIT_CLEARS_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !pause_o); // R11
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_zero |=> !pause_o); // R12
  AST_DISABLED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_zero && frm_valid_i) |=> dec_pass_o); // R12
endmodule

bind ingress_policer policer_checker #(
  .RATE_W(RATE_W), .INC_W(INC_W), .LIM_W(LIM_W)
) i_policer_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .rate_factor_i    (rate_factor_i),
  .incr_i           (incr_i),
  .cbs_i            (cbs_i),
  .ebs_i            (ebs_i),
  .exceed_fc_i      (exceed_fc_i),
  .release_at_cbs_i (release_at_cbs_i),
  .limit_en_i       (limit_en_i),
  .count_sel_i      (count_sel_i),
  .init_i           (init_i),
  .frm_valid_i      (frm_valid_i),
  .dec_valid_o      (dec_valid_o),
  .dec_pass_o       (dec_pass_o),
  .pause_o          (pause_o)
);

// File: tb/test_ingress_policer.sv
`timescale 1ns/1ps
module test_ingress_policer;
  localparam int CLK_NS = 20;
  localparam longint FILL_MAX = (64'd1 << 26) - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] rate_factor_i = '0;
  logic [11:0] incr_i = '0;
  logic [23:0] cbs_i = '0, ebs_i = '0;
  logic        exceed_fc_i = 1'b0, release_at_cbs_i = 1'b0, limit_en_i = 1'b0;
  logic [1:0]  count_sel_i = '0;
  logic        init_i = 1'b0, drain_tick_i = 1'b0, frm_valid_i = 1'b0;
  logic [15:0] frm_len_i = '0;
  logic        dec_valid_o, dec_pass_o, pause_o;

  int checks = 0, errors = 0;
  longint m_fill = 0;
  bit     m_pause = 1'b0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  ingress_policer i_ingress_policer (.*);

  function automatic longint qty_of(input logic [1:0] sel, input int len);
    case (sel)
      2'd0: return 1;
      2'd1: return len + 20;
      2'd2: return len;
      default: return (len >= 18) ? len - 18 : 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg(input int rate, input int inc, input int cbs, input int ebs,
                     input bit fc, input bit rel, input bit lim, input int sel);
    rate_factor_i = 16'(rate); incr_i = 12'(inc); cbs_i = 24'(cbs); ebs_i = 24'(ebs);
    exceed_fc_i = fc; release_at_cbs_i = rel; limit_en_i = lim; count_sel_i = 2'(sel);
  endtask

  // one cycle: drive at negedge, check at next negedge
  task automatic step(input string tag, input bit frm, input int len, input bit tick, input bit ini);
    bit dis, pass, charge, setp;
    longint cost, nf;
    bit np;
    frm_valid_i = frm; frm_len_i = 16'(len); drain_tick_i = tick; init_i = ini;
    dis = (rate_factor_i == 0) && (incr_i == 0) && (cbs_i == 0) && (ebs_i == 0) &&
          !exceed_fc_i && !release_at_cbs_i && !limit_en_i && (count_sel_i == 0);
    cost = qty_of(count_sel_i, len) * longint'(incr_i);
    pass = 1; charge = 0; setp = 0;
    if (frm && !dis) begin
      if (m_fill < cbs_i || !limit_en_i || m_fill + cost <= ebs_i) charge = 1;       // R3 R4 R7
      else if (exceed_fc_i) begin charge = 1; setp = 1; end                          // R6
      else pass = 0;                                                                 // R5
    end
    nf = m_fill + (charge ? cost : 0);
    if (nf > FILL_MAX) nf = FILL_MAX;
    if (tick) nf = (nf >= rate_factor_i) ? nf - rate_factor_i : 0;                   // R8
    if (ini || dis) nf = 0;
    np = m_pause;
    if (ini || dis) np = 0;
    else if (setp) np = 1;
    else if (m_pause && (release_at_cbs_i ? (nf < cbs_i) : (nf == 0))) np = 0;       // R9 R10
    @(negedge clk_i);
    chk(tag, "dec_valid", dec_valid_o, frm);
    if (frm) chk(tag, "dec_pass", dec_pass_o, pass);
    chk(tag, "pause", pause_o, np);
    m_fill = nf; m_pause = np;
    frm_valid_i = 0; drain_tick_i = 0; init_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cfg(0, 0, 0, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk_i);
    chk("R2", "reset dec_valid", dec_valid_o, 0);
    chk("R11", "reset pause", pause_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: each count encoding, then boundary frame of cost 3 and one over
    for (int s = 0; s < 4; s++) begin
      longint c1 = qty_of(2'(s), 100) * 3;
      cfg(0, 3, 1, int'(c1) + 3, 0, 0, 1, s);
      step("R11", 0, 0, 0, 1);
      step("R1", 1, 100, 0, 0);
      count_sel_i = 2'd0;
      step("R4", 1, 0, 0, 0);
      step("R5", 1, 0, 0, 0);
    end
    count_sel_i = 2'd3;
    step("R1", 1, 10, 0, 0);

    // R3: below committed passes despite tiny excess threshold
    cfg(0, 4, 1000, 10, 0, 0, 1, 2);
    step("R11", 0, 0, 0, 1);
    step("R3", 1, 1250, 0, 0);
    step("R5", 1, 1, 0, 0);

    // R6 + R9: pause, release only when empty
    cfg(7, 1, 10, 20, 1, 0, 1, 2);
    step("R11", 0, 0, 0, 1);
    step("R3", 1, 15, 0, 0);
    step("R6", 1, 15, 0, 0);
    for (int k = 0; k < 6; k++) step("R9", 0, 0, 1, 0);

    // R6 + R10: release below committed
    release_at_cbs_i = 1'b1;
    step("R11", 0, 0, 0, 1);
    step("R3", 1, 15, 0, 0);
    step("R6", 1, 15, 0, 0);
    for (int k = 0; k < 4; k++) step("R10", 0, 0, 1, 0);

    // R11: init during pause
    step("R6", 1, 40, 0, 0);
    step("R6", 1, 40, 0, 0);
    step("R11", 0, 0, 0, 1);
    step("R3", 1, 5, 0, 0);

    // R7: accept mode never drops
    cfg(0, 50, 1, 2, 0, 0, 0, 1);
    step("R11", 0, 0, 0, 1);
    for (int k = 0; k < 3; k++) step("R7", 1, 1500, 0, 0);

    // R8: same-cycle charge and drain, floor at zero, saturation
    cfg(30, 1, 25, 40, 0, 0, 1, 2);
    step("R11", 0, 0, 0, 1);
    step("R8", 1, 30, 1, 0);
    step("R8", 1, 38, 0, 0);
    step("R8", 0, 0, 1, 0);
    step("R8", 1, 40, 0, 0);
    cfg(65535, 4095, 100, 200, 0, 0, 1, 1);
    step("R8", 1, 65535, 0, 0);
    step("R8", 1, 65535, 0, 0);
    step("R8", 0, 0, 1, 0);
    step("R8", 1, 0, 0, 0);

    // R12: disabled resource
    cfg(0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) step("R12", 1, 1500, k == 1, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) begin
        int cb = int'($urandom_range(0, 2000));
        if ($urandom_range(0, 9) == 0) cfg(0, 0, 0, 0, 0, 0, 0, 0);
        else cfg(int'($urandom_range(0, 300)), int'($urandom_range(1, 4)), cb,
                 cb + int'($urandom_range(0, 3000)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
                 int'($urandom_range(0, 3)));
      end
      step("R2", 1'($urandom_range(0, 2) != 0), int'($urandom_range(0, 1500)),
           1'($urandom_range(0, 1)), $urandom_range(0, 199) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule